// File: doc/BRIEF.md
# Longest-Match Select Tree

This block picks the best of N unsorted match-length codes in one pass and reports both the winning code and the position of the entry that produced it. That position is then used as the pointer into a next-hop table. Because entries are unsorted, the block does not pick the first match by position. Instead, a binary tree of two-input compare-and-forward nodes keeps the larger code at each step. The tree has log2(N) levels and N-1 nodes.

Each code holds two thermometer fields. The first is a count of whole 8-bit groups that matched. The second is the count of matching bits in the next group. A node compares the two fields directly in thermometer form, and the group field takes precedence. Pipeline registers are placed after every LEVELS_PER_STAGE levels, and always after the last level. A new set of N codes can therefore enter on every clock, and each result leaves after a fixed latency. A valid flag travels with the data. A no-match flag tells the caller to use its default route.

Top module: `lpm_max_tree`

## Requirements
- R1: A code is 11 bits. Bits [10:7] hold the group count in thermometer form, filled from bit 7 upward. Bits [6:0] hold the sub-group count in thermometer form, filled from bit 0 upward. The output code equals the winning input code bit for bit.
- R2: An entry with a larger group count wins over one with a smaller group count, whatever the sub-group fields hold. No compare node ever sees its group field as both greater and less at once.
- R3: When the group counts are equal, the entry with the larger sub-group count wins.
- R4: When two or more entries hold the largest code, the lowest-numbered of them wins.
- R5: out_index is the number of the winning entry. Entry i occupies in_codes bits [11*i+10 : 11*i].
- R6: out_valid repeats in_valid exactly ceil(log2(N_ENTRIES)/LEVELS_PER_STAGE) cycles later. A new input set is accepted on every cycle, and back-to-back inputs give back-to-back results.
- R7: out_nomatch is 1 exactly when the output code is all zeros. A valid result with no match carries out_index 0.
- R8: While out_valid is 0, out_code and out_index keep the last result.
- R9: After reset, out_valid is 0, out_code and out_index are 0, and out_nomatch is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Marks in_codes as a set to be resolved |
| in_codes | input | N_ENTRIES*11 | Match-length codes, entry i at bits [11*i+10:11*i] |
| out_valid | output | 1 | A result is present on the output ports |
| out_code | output | 11 | Best code in the set |
| out_index | output | clog2(N_ENTRIES) | Number of the winning entry |
| out_nomatch | output | 1 | The best code is all zeros |

## Verification
A node with a wrong select would forward the wrong entry, and out_index would then point to a loser, or out_code would shrink. This shows on the first result whose winner passes through that node, after exactly the fixed latency. Sweeping a single non-zero code across every position catches a node or a leaf number that is swapped or stuck. Dense sets of ties, and codes that differ only in the sub-group field, expose a reversed tie rule or a field that takes wrong precedence. A pipeline stage with a missing or extra register shows at once as out_valid on the wrong cycle. A data register that ignores its enable shows on the first idle cycle, when the held output changes.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  localparam int GRP_W  = 4;
  localparam int SUB_W  = 7;
  localparam int CODE_W = GRP_W + SUB_W;
  localparam int FLD_W  = (GRP_W > SUB_W) ? GRP_W : SUB_W;

  typedef struct packed {
    logic [GRP_W-1:0] grp;
    logic [SUB_W-1:0] sub;
  } code_t;

  // x strictly exceeds y when x holds a set bit that y lacks (thermometer form)
  function automatic logic therm_gt(input logic [FLD_W-1:0] x, input logic [FLD_W-1:0] y);
    return |(x & ~y);
  endfunction

endpackage

// File: rtl/lpm_sel_node.sv
module lpm_sel_node
  import lpm_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  code_t            a_code,
  input  code_t            b_code,
  input  logic [IDX_W-1:0] a_idx,
  input  logic [IDX_W-1:0] b_idx,
  output code_t            y_code,
  output logic [IDX_W-1:0] y_idx,
  output logic             grp_gt,
  output logic             grp_lt,
  output logic             sub_gt,
  output logic             sub_lt
);

  logic take_b;

  always_comb begin
    grp_gt = therm_gt(FLD_W'(a_code.grp), FLD_W'(b_code.grp));
    grp_lt = therm_gt(FLD_W'(b_code.grp), FLD_W'(a_code.grp));
    sub_gt = therm_gt(FLD_W'(a_code.sub), FLD_W'(b_code.sub));
    sub_lt = therm_gt(FLD_W'(b_code.sub), FLD_W'(a_code.sub));
    // b only replaces a when strictly better; equal codes keep the lower entry
    take_b = grp_lt | (~grp_gt & sub_lt);
    y_code = take_b ? b_code : a_code;
    y_idx  = take_b ? b_idx  : a_idx;
  end

endmodule

// File: rtl/lpm_pipe_slot.sv
module lpm_pipe_slot
  import lpm_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  code_t            d_code,
  input  logic [IDX_W-1:0] d_idx,
  output code_t            q_code,
  output logic [IDX_W-1:0] q_idx
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_code <= '0;
      q_idx  <= '0;
    end else if (en) begin
      q_code <= d_code;
      q_idx  <= d_idx;
    end
  end

endmodule

// File: rtl/lpm_max_tree.sv
module lpm_max_tree
  import lpm_pkg::*;
#(
  parameter int N_ENTRIES        = 16,
  parameter int LEVELS_PER_STAGE = 1,
  localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic [N_ENTRIES*CODE_W-1:0]   in_codes,
  output logic                          out_valid,
  output logic [CODE_W-1:0]             out_code,
  output logic [IDX_W-1:0]              out_index,
  output logic                          out_nomatch
);

  localparam int LEVELS = $clog2(N_ENTRIES);
  localparam int NODES  = 2 * N_ENTRIES - 1;

  // Tree storage: level l occupies [2N - (2N >> l) +: N >> l]
  code_t            t_code [NODES];
  logic [IDX_W-1:0] t_idx  [NODES];
  logic             lv_vld [LEVELS+1];

  // One flag per compare node: a field reported both greater and less
  logic [N_ENTRIES-2:0] node_conflict;

  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_leaf
    assign t_code[i] = code_t'(in_codes[i*CODE_W +: CODE_W]);
    assign t_idx[i]  = IDX_W'(i);
  end

  assign lv_vld[0] = in_valid;

  for (genvar l = 1; l <= LEVELS; l++) begin : g_lvl
    localparam int  W      = N_ENTRIES >> l;
    localparam int  BASE_I = 2 * N_ENTRIES - ((2 * N_ENTRIES) >> (l - 1));
    localparam int  BASE_O = 2 * N_ENTRIES - ((2 * N_ENTRIES) >> l);
    localparam bit  IS_REG = ((l % LEVELS_PER_STAGE) == 0) || (l == LEVELS);

    if (IS_REG) begin : g_vreg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lv_vld[l] <= 1'b0;
        else        lv_vld[l] <= lv_vld[l-1];
      end
    end else begin : g_vwire
      assign lv_vld[l] = lv_vld[l-1];
    end

    for (genvar i = 0; i < W; i++) begin : g_node
      code_t            n_code;
      logic [IDX_W-1:0] n_idx;
      logic             n_ggt, n_glt, n_sgt, n_slt;

      lpm_sel_node #(.IDX_W(IDX_W)) u_node (
        .a_code (t_code[BASE_I + 2*i]),
        .b_code (t_code[BASE_I + 2*i + 1]),
        .a_idx  (t_idx[BASE_I + 2*i]),
        .b_idx  (t_idx[BASE_I + 2*i + 1]),
        .y_code (n_code),
        .y_idx  (n_idx),
        .grp_gt (n_ggt),
        .grp_lt (n_glt),
        .sub_gt (n_sgt),
        .sub_lt (n_slt)
      );

      assign node_conflict[BASE_O - N_ENTRIES + i] = (n_ggt & n_glt) | (n_sgt & n_slt);

      if (IS_REG) begin : g_reg
        lpm_pipe_slot #(.IDX_W(IDX_W)) u_slot (
          .clk    (clk),
          .rst_n  (rst_n),
          .en     (lv_vld[l-1]),
          .d_code (n_code),
          .d_idx  (n_idx),
          .q_code (t_code[BASE_O + i]),
          .q_idx  (t_idx[BASE_O + i])
        );
      end else begin : g_wire
        assign t_code[BASE_O + i] = n_code;
        assign t_idx[BASE_O + i]  = n_idx;
      end
    end
  end

  assign out_valid   = lv_vld[LEVELS];
  assign out_code    = t_code[NODES-1];
  assign out_index   = t_idx[NODES-1];
  assign out_nomatch = ~|t_code[NODES-1];

endmodule

// File: rtl/lpm_max_tree_chk.sv
module lpm_max_tree_chk #(
  parameter int N_ENTRIES        = 16,
  parameter int LEVELS_PER_STAGE = 1,
  localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 out_valid,
  input logic [10:0]          out_code,
  input logic [IDX_W-1:0]     out_index,
  input logic                 out_nomatch,
  input logic [N_ENTRIES-2:0] node_conflict
);

  localparam int LEVELS = $clog2(N_ENTRIES);
  localparam int LAT    = (LEVELS + LEVELS_PER_STAGE - 1) / LEVELS_PER_STAGE;

  logic [LAT-1:0] vld_hist;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_hist <= '0;
    else        vld_hist <= LAT'({vld_hist, in_valid});
  end

  logic [3:0] o_grp;
  logic [6:0] o_sub;
  assign o_grp = out_code[10:7];
  assign o_sub = out_code[6:0];

  assert_valid_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == vld_hist[LAT-1]);

  assert_code_shape_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (((o_grp + 4'd1) & o_grp) == 4'd0) && (((o_sub + 7'd1) & o_sub) == 7'd0));

  assert_nomatch_index_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_nomatch) |-> (out_index == '0));

  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_code) && $stable(out_index)));

  assert_field_consistent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    node_conflict == '0);

endmodule

bind lpm_max_tree lpm_max_tree_chk #(
  .N_ENTRIES        (N_ENTRIES),
  .LEVELS_PER_STAGE (LEVELS_PER_STAGE)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .out_valid     (out_valid),
  .out_code      (out_code),
  .out_index     (out_index),
  .out_nomatch   (out_nomatch),
  .node_conflict (node_conflict)
);

// File: tb/lpm_max_tree_tb.sv
`timescale 1ns/1ps
module lpm_max_tree_tb;

  localparam int N   = 8;
  localparam int LPS = 2;
  localparam int CW  = 11;
  localparam int IW  = 3;
  localparam int LAT = 2;   // ceil(3 levels / 2 per stage)

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic [N*CW-1:0] in_codes = '0;
  logic            out_valid;
  logic [CW-1:0]   out_code;
  logic [IW-1:0]   out_index;
  logic            out_nomatch;

  always #2.5 clk = ~clk;

  lpm_max_tree #(.N_ENTRIES(N), .LEVELS_PER_STAGE(LPS)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_codes(in_codes),
    .out_valid(out_valid), .out_code(out_code), .out_index(out_index),
    .out_nomatch(out_nomatch)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [LAT-1:0] hist = '0;
  logic [CW-1:0]  held_code = '0;
  logic [IW-1:0]  held_idx = '0;
  logic [CW-1:0]  q_code [$];
  int             q_idx  [$];

  function automatic logic [CW-1:0] mk(input int g, input int s);
    logic [3:0] gv;
    logic [6:0] sv;
    gv = 4'((1 << g) - 1);
    sv = 7'((1 << s) - 1);
    return {gv, sv};
  endfunction

  function automatic int klen(input logic [CW-1:0] c);
    return $countones(c[10:7]) * 8 + $countones(c[6:0]);
  endfunction

  function automatic logic [N*CW-1:0] rnd(input int gmax, input int smax);
    logic [N*CW-1:0] v;
    for (int i = 0; i < N; i++)
      v[i*CW +: CW] = mk($urandom_range(gmax, 0), $urandom_range(smax, 0));
    return v;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit v, input logic [N*CW-1:0] codes);
    int best;
    @(negedge clk);
    chk(out_valid == hist[LAT-1], "R6", "out_valid", int'(out_valid), int'(hist[LAT-1]));
    if (out_valid) begin
      if (q_code.size() == 0) begin
        chk(1'b0, "R6", "result without input", 1, 0);
      end else begin
        logic [CW-1:0] ec;
        int ei;
        ec = q_code.pop_front();
        ei = q_idx.pop_front();
        chk(out_code == ec, "R1 R2 R3", "out_code", int'(out_code), int'(ec));
        chk(int'(out_index) == ei, "R4 R5", "out_index", int'(out_index), ei);
        chk(out_nomatch == (ec == '0), "R7", "out_nomatch", int'(out_nomatch), int'(ec == '0));
        held_code = ec;
        held_idx  = IW'(ei);
      end
    end else begin
      chk(out_code == held_code, "R8", "held out_code", int'(out_code), int'(held_code));
      chk(out_index == held_idx, "R8", "held out_index", int'(out_index), int'(held_idx));
    end
    if (v) begin
      best = 0;
      for (int i = 1; i < N; i++)
        if (klen(codes[i*CW +: CW]) > klen(codes[best*CW +: CW])) best = i;
      q_code.push_back(codes[best*CW +: CW]);
      q_idx.push_back(best);
    end
    hist = {hist[LAT-2:0], v};
    in_valid = v;
    in_codes = codes;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R6 watchdog: cycles actual %0d expected below %0d", 100000, 100000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [N*CW-1:0] v;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(out_valid == 1'b0, "R9", "reset out_valid", int'(out_valid), 0);
    chk(out_code == '0, "R9", "reset out_code", int'(out_code), 0);
    chk(out_index == '0, "R9", "reset out_index", int'(out_index), 0);
    chk(out_nomatch == 1'b1, "R9", "reset out_nomatch", int'(out_nomatch), 1);
    rst_n = 1'b1;

    // R7: nothing matches
    step(1'b1, '0);
    // R4: all equal
    for (int i = 0; i < N; i++) v[i*CW +: CW] = mk(2, 3);
    step(1'b1, v);
    // R2: one more group beats a full sub field
    v = '0; v[0*CW +: CW] = mk(0, 7); v[5*CW +: CW] = mk(1, 0);
    step(1'b1, v);
    // R3: equal groups, sub field decides
    for (int i = 0; i < N; i++) v[i*CW +: CW] = mk(3, 1);
    v[2*CW +: CW] = mk(3, 2); v[6*CW +: CW] = mk(3, 5);
    step(1'b1, v);
    // R5: best at the last entry
    v = rnd(3, 7); v[7*CW +: CW] = mk(4, 0);
    step(1'b1, v);
    // R4: duplicated best at entries 3 and 6
    v = '0; v[3*CW +: CW] = mk(2, 6); v[6*CW +: CW] = mk(2, 6); v[1*CW +: CW] = mk(2, 5);
    step(1'b1, v);
    step(1'b0, rnd(4, 7));
    step(1'b0, rnd(4, 7));

    // R5: one non-zero code swept over every position and length
    for (int p = 0; p < N; p++)
      for (int g = 0; g <= 4; g++)
        for (int s = 0; s <= 7; s++) begin
          if (g == 0 && s == 0) continue;
          v = '0;
          v[p*CW +: CW] = mk(g, s);
          step(1'b1, v);
        end

    // R2 R3 R6 R8: full-range sets with gaps
    for (int n = 0; n < 2000; n++)
      step($urandom_range(3, 0) != 0, rnd(4, 7));
    // R4: narrow range, many ties
    for (int n = 0; n < 2000; n++)
      step($urandom_range(3, 0) != 0, rnd(1, 2));

    repeat (LAT + 2) step(1'b0, rnd(4, 7));
    chk(q_code.size() == 0, "R6", "results outstanding", q_code.size(), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule